// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock. A slow oscillator strobe (one enable pulse per 32.768 kHz period, synchronous to the bus clock) feeds a prescaler. The prescaler produces one tick per second, and each tick advances a 32-bit seconds counter. The prescaler period is set by a divider field, and a trim field can lengthen one period in a fixed group of seconds to correct the average rate. If the whole trim/divider register is zero, the prescaler runs from a built-in default divider, so the clock keeps time before any setup has been done.

A 32-bit alarm value is compared with the counter on every tick. Two sticky event flags record a tick and an alarm match. Two enable bits route those flags to two separate level interrupt outputs. Software clears a flag by writing a one to its bit position. All state is reached over a simple single-cycle register bus with byte addresses on word boundaries, and every register resets to zero.

Top module: `rtc_seconds_top`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: While the trim/divider register holds zero, a tick occurs every DEF_DIV+1 oscillator strobes.
- R3: With a nonzero trim/divider value, the divider sits in bits 15:0 and a tick occurs every divider+1 strobes. A write to this register restarts the prescaler phase and the trim group, and no tick occurs in the cycle of that write.
- R4: The trim value in bits 31:16 lengthens the last period of each group of TRIM_PERIOD ticks (the group is counted from the last trim/divider write) by the trim value in strobes.
- R5: Each tick adds one to the seconds counter, which wraps from 0xFFFFFFFF to 0. Without a tick or a write the counter holds its value.
- R6: A bus write to the counter in the same cycle as a tick stores the written value, and the tick's increment is lost.
- R7: Every tick sets the tick flag (status bit 1) whatever the enables are. The flag stays set until it is cleared.
- R8: A tick that brings the counter to the alarm value sets the alarm flag (status bit 0). A bus write to the counter never sets it.
- R9: Writing status bits 1 and 0 as one clears the matching flag, and writing zero leaves it unchanged. A flag that is set in the same cycle as a clear write stays set. Each status write loads the tick enable (bit 3) and the alarm enable (bit 2) from the written data.
- R10: irq_tick is high exactly while the tick flag and the tick enable are both one. irq_alarm is high exactly while the alarm flag and the alarm enable are both one.
- R11: Byte addresses map alarm to 0x00, counter to 0x04, trim/divider to 0x08 and status to 0x10. Every other address, including addresses that are not word aligned, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_ce | input | 1 | One-cycle strobe per oscillator period |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_tick | output | 1 | Tick interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with DEF_DIV set to 7 and TRIM_PERIOD set to 4. A default-divider second then lasts eight strobes, and a whole trim group completes in a few dozen strobes, so the default fallback, the stretched period and its return to the normal length can all be counted strobe by strobe. The bench drives the oscillator strobe by hand. This lets it place a tick in exactly the cycle of a counter write or a flag clear, which the collision requirements need.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Byte offsets of the registers on the bus
  localparam int unsigned OFF_ALARM   = 32'h00;
  localparam int unsigned OFF_COUNT   = 32'h04;
  localparam int unsigned OFF_TRIMDIV = 32'h08;
  localparam int unsigned OFF_STATUS  = 32'h10;

  // Status bit positions
  localparam int unsigned ST_AL_FL = 0;
  localparam int unsigned ST_HZ_FL = 1;
  localparam int unsigned ST_AL_EN = 2;
  localparam int unsigned ST_HZ_EN = 3;
  localparam int unsigned ST_W     = 4;

  // Packed so that the read value lines up with the bit positions above
  typedef struct packed {
    logic hz_en;
    logic al_en;
    logic hz_fl;
    logic al_fl;
  } status_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 16,
  parameter int DEF_DIV     = 32767,
  parameter int TRIM_PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_ce,
  input  logic              td_wr,
  input  logic [DATA_W-1:0] td_wdata,
  output logic [DATA_W-1:0] td_q,
  output logic              tick
);

  localparam int TRIM_W = DATA_W - DIV_W;
  localparam int PRE_W  = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;
  localparam int GRP_W  = (TRIM_PERIOD > 2) ? $clog2(TRIM_PERIOD) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(TRIM_PERIOD - 1);

  // Divider that is in force: the default one while the register is all zero
  function automatic logic [PRE_W-1:0] eff_div(input logic [DATA_W-1:0] raw);
    if (raw == '0) return PRE_W'(DEF_DIV);
    return PRE_W'(raw[DIV_W-1:0]);
  endfunction

  // Last prescaler count of the current period, stretched by trim if asked
  function automatic logic [PRE_W-1:0] last_cnt(input logic [PRE_W-1:0] d,
                                                input logic [TRIM_W-1:0] t,
                                                input logic s);
    return s ? (d + PRE_W'(t)) : d;
  endfunction

  logic [DATA_W-1:0] td_r;
  logic [PRE_W-1:0]  pre_cnt;
  logic [GRP_W-1:0]  grp_cnt;
  logic              stretch;
  logic [PRE_W-1:0]  lim;
  logic              at_end;

  assign stretch = (grp_cnt == GRP_LAST);
  assign lim     = last_cnt(eff_div(td_r), td_r[DATA_W-1:DIV_W], stretch);
  assign at_end  = (pre_cnt == lim);
  assign tick    = osc_ce && at_end && !td_wr;
  assign td_q    = td_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      td_r    <= '0;
      pre_cnt <= '0;
      grp_cnt <= '0;
    end else if (td_wr) begin
      td_r    <= td_wdata;
      pre_cnt <= '0;
      grp_cnt <= '0;
    end else if (osc_ce) begin
      if (at_end) begin
        pre_cnt <= '0;
        grp_cnt <= stretch ? '0 : grp_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R3: the phase counter never runs past the end of the current period
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= lim);

  // R3: a register write restarts the phase from zero
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    td_wr |=> (pre_cnt == '0));

  // R4: the group position wraps after the stretched period
  p_grp_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stretch) |=> (grp_cnt == '0));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_wr,
  input  logic              alarm_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] alarm_q,
  output logic              alarm_hit
);

  // Next seconds value, wrapping at the top
  function automatic logic [DATA_W-1:0] next_sec(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [DATA_W-1:0] cnt_r;
  logic [DATA_W-1:0] alarm_r;
  logic [DATA_W-1:0] cnt_inc;

  assign cnt_inc   = next_sec(cnt_r);
  assign alarm_hit = tick && !cnt_wr && (cnt_inc == alarm_r);
  assign cnt_q     = cnt_r;
  assign alarm_q   = alarm_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r   <= '0;
      alarm_r <= '0;
    end else begin
      if (cnt_wr)    cnt_r <= wdata;
      else if (tick) cnt_r <= cnt_inc;
      if (alarm_wr)  alarm_r <= wdata;
    end
  end

  // R5: one step per tick, wrapping
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt_r == $past(cnt_r) + 1'b1));

  // R5: hold without tick or write
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_r));

  // R6: a write wins over a tick
  p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_r == $past(wdata)));

  // R8: a match means the counter now equals the alarm
  p_hit_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !alarm_wr) |=> (cnt_r == alarm_r));

endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            alarm_hit,
  input  logic            st_wr,
  input  logic [ST_W-1:0] st_wdata,
  output status_t         st_q,
  output logic            irq_tick,
  output logic            irq_alarm
);

  status_t st_r;
  logic    clr_hz;
  logic    clr_al;

  assign clr_hz = st_wr && st_wdata[ST_HZ_FL];
  assign clr_al = st_wr && st_wdata[ST_AL_FL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_r <= '0;
    end else begin
      if (st_wr) begin
        st_r.hz_en <= st_wdata[ST_HZ_EN];
        st_r.al_en <= st_wdata[ST_AL_EN];
      end
      // A new event takes priority over a clear in the same cycle
      if (tick)        st_r.hz_fl <= 1'b1;
      else if (clr_hz) st_r.hz_fl <= 1'b0;
      if (alarm_hit)   st_r.al_fl <= 1'b1;
      else if (clr_al) st_r.al_fl <= 1'b0;
    end
  end

  assign st_q      = st_r;
  assign irq_tick  = st_r.hz_fl && st_r.hz_en;
  assign irq_alarm = st_r.al_fl && st_r.al_en;

  // R7: every tick leaves the flag set
  p_hz_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> st_r.hz_fl);

  // R7: the flag is sticky unless cleared
  p_hz_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r.hz_fl && !clr_hz) |=> st_r.hz_fl);

  // R8: a match sets the alarm flag
  p_al_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> st_r.al_fl);

  // R9: a clear with no new event drops the flag
  p_al_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_al && !alarm_hit) |=> !st_r.al_fl);

  // R10: a disabled source never interrupts
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_r.hz_en |-> !irq_tick) and (!st_r.al_en |-> !irq_alarm));

endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
  import rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 16,
  parameter int DEF_DIV     = 32767,
  parameter int TRIM_PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_ce,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tick,
  output logic              irq_alarm
);

  localparam logic [ADDR_W-1:0] A_ALARM   = ADDR_W'(OFF_ALARM);
  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_TRIMDIV = ADDR_W'(OFF_TRIMDIV);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);

  logic hit_alarm, hit_count, hit_td, hit_st;
  logic wr;
  logic tick;
  logic alarm_hit;
  logic [DATA_W-1:0] td_q, cnt_q, alarm_q;
  status_t st_q;

  assign hit_alarm = (bus_addr == A_ALARM);
  assign hit_count = (bus_addr == A_COUNT);
  assign hit_td    = (bus_addr == A_TRIMDIV);
  assign hit_st    = (bus_addr == A_STATUS);
  assign wr        = bus_sel && bus_we;

  rtc_prescaler #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .TRIM_PERIOD(TRIM_PERIOD)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce),
    .td_wr(wr && hit_td), .td_wdata(bus_wdata),
    .td_q(td_q), .tick(tick)
  );

  rtc_sec_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_wr(wr && hit_count), .alarm_wr(wr && hit_alarm),
    .wdata(bus_wdata), .cnt_q(cnt_q), .alarm_q(alarm_q),
    .alarm_hit(alarm_hit)
  );

  rtc_status u_st (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_hit(alarm_hit),
    .st_wr(wr && hit_st), .st_wdata(bus_wdata[ST_W-1:0]),
    .st_q(st_q), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_alarm)      bus_rdata = alarm_q;
      else if (hit_count) bus_rdata = cnt_q;
      else if (hit_td)    bus_rdata = td_q;
      else if (hit_st)    bus_rdata = {{(DATA_W-ST_W){1'b0}}, st_q};
    end
  end

  // R11: an unmapped write leaves the counter alone unless a tick moves it
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_alarm && !hit_count && !hit_td && !hit_st && !tick)
      |=> $stable(cnt_q));

endmodule

// File: tb/test_rtc_seconds_top.sv
`timescale 1ns/1ps
module test_rtc_seconds_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_ce = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick, irq_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [4:0] A_AL = 5'h00, A_CN = 5'h04, A_TD = 5'h08, A_ST = 5'h10;

  always #2 clk = ~clk;

  rtc_seconds_top #(.DEF_DIV(7), .TRIM_PERIOD(4)) i_rtc_seconds_top (
    .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  typedef struct {
    logic [4:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  event  ev_smp;

  // Monitor: pops one expected read per sample request
  initial begin
    forever begin
      @(ev_smp);
      #1;
      if (sb.size() != 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.e) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
    -> ev_smp;
    #1.5;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic ce);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; osc_ce = ce;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; osc_ce = 1'b0;
  endtask

  task automatic pulse(input int n);
    if (n > 0) begin
      @(negedge clk);
      osc_ce = 1'b1;
      repeat (n) @(negedge clk);
      osc_ce = 1'b0;
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    @(negedge clk);
    #1;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_AL, 32'h0, "R1 alarm");
    rd(A_CN, 32'h0, "R1 counter");
    rd(A_TD, 32'h0, "R1 trimdiv");
    rd(A_ST, 32'h0, "R1 status");
    chk_bit(irq_tick, 1'b0, "R1 irq_tick");
    chk_bit(irq_alarm, 1'b0, "R1 irq_alarm");
    rd(5'h0C, 32'h0, "R11 unmapped read");

    // R2 default divider: 8 strobes per tick
    pulse(7);
    rd(A_CN, 32'h0, "R2 before tick");
    pulse(1);
    rd(A_CN, 32'h1, "R2 on 8th strobe");
    rd(A_ST, 32'h2, "R7 tick flag set");

    // R9 clear by one, zero leaves
    wr(A_ST, 32'h2, 1'b0);
    rd(A_ST, 32'h0, "R9 clear by one");
    pulse(8);
    wr(A_ST, 32'h0, 1'b0);
    rd(A_ST, 32'h2, "R9 zero leaves flag");
    wr(A_ST, 32'hA, 1'b0);
    rd(A_ST, 32'h8, "R9 enable loaded, flag cleared");
    chk_bit(irq_tick, 1'b0, "R10 enabled but no flag");
    pulse(8);
    rd(A_ST, 32'hA, "R7 flag set with enable");
    chk_bit(irq_tick, 1'b1, "R10 irq_tick high");
    rd(A_CN, 32'h3, "R5 count after three ticks");
    wr(A_ST, 32'h2, 1'b0);
    chk_bit(irq_tick, 1'b0, "R10 irq_tick low after clear");

    // R3 programmed divider 4: 5 strobes
    wr(A_TD, 32'h4, 1'b0);
    rd(A_TD, 32'h4, "R11 trimdiv readback");
    pulse(4);
    rd(A_CN, 32'h3, "R3 before tick");
    pulse(1);
    rd(A_CN, 32'h4, "R3 tick at 5th strobe");

    // R4 trim 3, group of 4: 5,5,5,8
    wr(A_TD, 32'h0003_0004, 1'b0);
    pulse(15);
    rd(A_CN, 32'h7, "R4 three normal periods");
    pulse(7);
    rd(A_CN, 32'h7, "R4 stretched period not done");
    pulse(1);
    rd(A_CN, 32'h8, "R4 stretched period ends");
    pulse(5);
    rd(A_CN, 32'h9, "R4 back to normal period");

    // R5 wrap
    wr(A_CN, 32'hFFFF_FFFF, 1'b0);
    rd(A_CN, 32'hFFFF_FFFF, "R5 written value");
    pulse(5);
    rd(A_CN, 32'h0, "R5 wrap to zero");

    // R6 write collides with tick
    pulse(4);
    wr(A_CN, 32'h100, 1'b1);
    rd(A_CN, 32'h100, "R6 write wins over tick");

    // R8 alarm
    wr(A_TD, 32'h4, 1'b0);
    wr(A_AL, 32'h105, 1'b0);
    wr(A_ST, 32'h3, 1'b0);
    pulse(20);
    rd(A_CN, 32'h104, "R8 counter before match");
    rd(A_ST, 32'h2, "R8 no alarm flag yet");
    pulse(5);
    rd(A_ST, 32'h3, "R8 alarm flag on match");
    chk_bit(irq_alarm, 1'b0, "R10 alarm disabled");
    wr(A_ST, 32'h4, 1'b0);
    chk_bit(irq_alarm, 1'b1, "R10 irq_alarm high");

    // R9 set wins over clear
    pulse(4);
    wr(A_ST, 32'h6, 1'b1);
    rd(A_ST, 32'h7, "R9 set beats clear");
    rd(A_CN, 32'h106, "R5 count after collision tick");
    wr(A_ST, 32'h1, 1'b0);
    rd(A_ST, 32'h2, "R9 alarm flag cleared");
    chk_bit(irq_alarm, 1'b0, "R10 irq_alarm low");

    // R8 write to the alarm value does not set the flag
    wr(A_CN, 32'h105, 1'b0);
    rd(A_ST, 32'h2, "R8 write match ignored");

    // R11 unmapped and misaligned writes ignored
    wr(5'h0C, 32'hFFFF_FFFF, 1'b0);
    wr(5'h05, 32'h0, 1'b0);
    wr(5'h11, 32'hF, 1'b0);
    rd(5'h0C, 32'h0, "R11 unmapped still zero");
    rd(A_AL, 32'h105, "R11 alarm untouched");
    rd(A_CN, 32'h105, "R11 counter untouched");
    rd(A_TD, 32'h4, "R11 trimdiv untouched");
    rd(A_ST, 32'h2, "R11 status untouched");

    #5;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule